// File: doc/BRIEF.md
# Deferred Floating-Point Trap Queue Drain Sequencer

After a deferred floating-point trap, the processor holds a short queue of floating-point instructions that have not completed. Each entry carries an instruction word and the address it came from. This sequencer replays those entries through an execution unit so that the stalled program can continue. The entries go out strictly one at a time, and the sequencer waits for a pass or fail answer before it issues the next one. It stops at the first failure. When it is done, it writes back a cleaned floating-point status word and tells the queue owner to reset its depth to zero.

If the queue is empty, the trap was precise. In that case the sequencer fetches the offending instruction from the current program counter and executes it alone. If that works, it moves the program counter to the saved next value and advances the next value by one instruction.

Both the instruction fetch path and the execution unit are request/acknowledge ports. Each acknowledge carries a pass/fail bit. At the end of every run the block gives a one-cycle completion pulse with an overall result bit.

Top module: `fpq_drain`

## Requirements
- R1: After reset, `done_o`, `fetch_req_o`, `exec_req_o`, `q_clear_o`, `status_we_o` and `pc_we_o` are all low until `start_i` is seen.
- R2: For a queue depth N between 1 and QDEPTH, entries are issued from index 0 up to N-1 in order. Entry i is the 32-bit slice `[i*32 +: 32]` of `q_insn_i` and `q_addr_i`. Only one request is outstanding at a time, and the next one is issued only after `exec_ack_i`.
- R3: An entry acknowledged with `exec_ok_i` low ends the drain immediately. No later entry is issued.
- R4: At the end of a queued drain, `status_we_o` is high for one cycle and `status_o` equals `status_i` with bits 13:12 cleared. Bits 4:0 are cleared as well only if every entry passed. All other bits pass through unchanged.
- R5: `q_clear_o` is high for one cycle at the end of every queued drain, whether it passed or failed.
- R6: `done_o` is a one-cycle pulse ending each run. `result_o` is high with it only if every executed operation passed.
- R7: With depth 0, the block fetches from address `pc_i` and then issues the fetched word once to the execution unit, with `pc_i` as its address.
- R8: A passing precise run raises `pc_we_o` with `done_o`, with `pc_o` equal to the captured `npc_i` and `npc_o` equal to that value plus 4, modulo 2^32.
- R9: A failed fetch in a precise run ends it with a failing result. No execution request is made and `pc_we_o` stays low.
- R10: A precise run whose execution fails reports failure and raises none of `pc_we_o`, `status_we_o` or `q_clear_o`.
- R11: `start_i` is ignored while a run is in progress. The run continues with the depth it captured, and no second run follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin trap handling (taken only when idle) |
| q_depth_i | input | $clog2(QDEPTH+1) | Number of valid queue entries; 0 selects a precise trap |
| q_insn_i | input | QDEPTH*XLEN | Queued instruction words, entry i at [i*XLEN +: XLEN] |
| q_addr_i | input | QDEPTH*XLEN | Queued instruction addresses, same layout |
| pc_i | input | XLEN | Current program counter |
| npc_i | input | XLEN | Current next program counter |
| status_i | input | XLEN | Current floating-point status word |
| fetch_req_o | output | 1 | Instruction fetch request, held until acknowledged |
| fetch_addr_o | output | XLEN | Fetch address |
| fetch_ack_i | input | 1 | Fetch response valid |
| fetch_ok_i | input | 1 | Fetch succeeded |
| fetch_data_i | input | XLEN | Fetched instruction word |
| exec_req_o | output | 1 | One-cycle execute request |
| exec_insn_o | output | XLEN | Instruction to execute |
| exec_addr_o | output | XLEN | Address of that instruction |
| exec_ack_i | input | 1 | Execution response valid |
| exec_ok_i | input | 1 | Execution passed |
| done_o | output | 1 | Run complete pulse |
| result_o | output | 1 | Overall pass (valid with done_o) |
| q_clear_o | output | 1 | Reset queue depth to zero |
| status_we_o | output | 1 | Write status_o into the status register |
| status_o | output | XLEN | Cleaned status word |
| pc_we_o | output | 1 | Write pc_o/npc_o |
| pc_o | output | XLEN | New program counter |
| npc_o | output | XLEN | New next program counter |

## Verification
A corrupted entry index is visible at the ports on the next `exec_req_o`: the instruction/address pair no longer matches the expected slice, or the number of issued entries changes. A lost fail flag appears within the same run as a wrong `result_o` and as status bits 4:0 that are cleared when they should be kept. A wrong precise/queued mode flag appears right away: a fetch where none is due, or the wrong choice among `pc_we_o`, `status_we_o` and `q_clear_o` in the completion cycle. Exercising every one of these needs these cases: a full queue, a failure at the first and at a middle entry, a start that arrives while busy, and a next-PC value at the wrap point.

// File: rtl/fpq_drain_pkg.sv
package fpq_drain_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH,
    ST_ISSUE,
    ST_WAIT,
    ST_FINISH
  } drain_state_e;

  // status word fields decoded by the surrounding FP unit
  localparam int unsigned QSTAT_LO = 12;
  localparam int unsigned QSTAT_W  = 2;
  localparam int unsigned CUREXC_W = 5;
endpackage

// File: rtl/fpq_entry_sel.sv
module fpq_entry_sel #(
  parameter int unsigned N  = 8,
  parameter int unsigned W  = 32,
  parameter int unsigned IW = 3
) (
  input  logic [N*W-1:0] insn_flat_i,
  input  logic [N*W-1:0] addr_flat_i,
  input  logic [IW-1:0]  idx_i,
  output logic [W-1:0]   insn_o,
  output logic [W-1:0]   addr_o
);
  logic [W-1:0] insn_arr [N];
  logic [W-1:0] addr_arr [N];

  for (genvar g = 0; g < N; g++) begin : g_unpack
    assign insn_arr[g] = insn_flat_i[g*W +: W];
    assign addr_arr[g] = addr_flat_i[g*W +: W];
  end

  always_comb begin
    insn_o = '0;
    addr_o = '0;
    for (int k = 0; k < N; k++) begin
      if (idx_i == IW'(k)) begin
        insn_o = insn_arr[k];
        addr_o = addr_arr[k];
      end
    end
  end
endmodule

// File: rtl/fpq_pc_step.sv
module fpq_pc_step #(
  parameter int unsigned XLEN = 32,
  parameter int unsigned STEP = 4
) (
  input  logic [XLEN-1:0] npc_i,
  output logic [XLEN-1:0] pc_o,
  output logic [XLEN-1:0] npc_o
);
  assign pc_o  = npc_i;
  assign npc_o = npc_i + XLEN'(STEP);
endmodule

// File: rtl/fpq_status_fix.sv
module fpq_status_fix
  import fpq_drain_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [XLEN-1:0] status_i,
  input  logic            all_ok_i,
  output logic [XLEN-1:0] status_o
);
  always_comb begin
    status_o = status_i;
    status_o[QSTAT_LO +: QSTAT_W] = '0;
    if (all_ok_i) status_o[CUREXC_W-1:0] = '0;
  end
endmodule

// File: rtl/fpq_drain.sv
module fpq_drain
  import fpq_drain_pkg::*;
#(
  parameter int unsigned QDEPTH  = 8,
  parameter int unsigned XLEN    = 32,
  parameter int unsigned PC_STEP = 4,
  localparam int unsigned CW     = $clog2(QDEPTH + 1),
  localparam int unsigned IW     = (QDEPTH > 1) ? $clog2(QDEPTH) : 1
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   start_i,
  input  logic [CW-1:0]          q_depth_i,
  input  logic [QDEPTH*XLEN-1:0] q_insn_i,
  input  logic [QDEPTH*XLEN-1:0] q_addr_i,
  input  logic [XLEN-1:0]        pc_i,
  input  logic [XLEN-1:0]        npc_i,
  input  logic [XLEN-1:0]        status_i,
  output logic                   fetch_req_o,
  output logic [XLEN-1:0]        fetch_addr_o,
  input  logic                   fetch_ack_i,
  input  logic                   fetch_ok_i,
  input  logic [XLEN-1:0]        fetch_data_i,
  output logic                   exec_req_o,
  output logic [XLEN-1:0]        exec_insn_o,
  output logic [XLEN-1:0]        exec_addr_o,
  input  logic                   exec_ack_i,
  input  logic                   exec_ok_i,
  output logic                   done_o,
  output logic                   result_o,
  output logic                   q_clear_o,
  output logic                   status_we_o,
  output logic [XLEN-1:0]        status_o,
  output logic                   pc_we_o,
  output logic [XLEN-1:0]        pc_o,
  output logic [XLEN-1:0]        npc_o
);
  drain_state_e    state_q;
  logic [IW-1:0]   idx_q, last_q;
  logic            precise_q, ok_q;
  logic [XLEN-1:0] cur_insn_q, pc_q, npc_q;
  logic [CW-1:0]   eff_depth, eff_m1;
  logic [XLEN-1:0] sel_insn, sel_addr;

  // depths beyond the queue size are clamped
  assign eff_depth = (q_depth_i > CW'(QDEPTH)) ? CW'(QDEPTH) : q_depth_i;
  assign eff_m1    = eff_depth - CW'(1);

  fpq_entry_sel #(.N(QDEPTH), .W(XLEN), .IW(IW)) u_sel (
    .insn_flat_i (q_insn_i),
    .addr_flat_i (q_addr_i),
    .idx_i       (idx_q),
    .insn_o      (sel_insn),
    .addr_o      (sel_addr)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      idx_q      <= '0;
      last_q     <= '0;
      precise_q  <= 1'b0;
      ok_q       <= 1'b0;
      cur_insn_q <= '0;
      pc_q       <= '0;
      npc_q      <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          pc_q   <= pc_i;
          npc_q  <= npc_i;
          idx_q  <= '0;
          ok_q   <= 1'b1;
          last_q <= IW'(eff_m1);
          if (eff_depth == '0) begin
            precise_q <= 1'b1;
            state_q   <= ST_FETCH;
          end else begin
            precise_q <= 1'b0;
            state_q   <= ST_ISSUE;
          end
        end
        ST_FETCH: if (fetch_ack_i) begin
          if (fetch_ok_i) begin
            cur_insn_q <= fetch_data_i;
            state_q    <= ST_ISSUE;
          end else begin
            ok_q    <= 1'b0;
            state_q <= ST_FINISH;
          end
        end
        ST_ISSUE: state_q <= ST_WAIT;
        ST_WAIT: if (exec_ack_i) begin
          if (!exec_ok_i) begin
            ok_q    <= 1'b0;
            state_q <= ST_FINISH;
          end else if (precise_q || idx_q == last_q) begin
            state_q <= ST_FINISH;
          end else begin
            idx_q   <= idx_q + IW'(1);
            state_q <= ST_ISSUE;
          end
        end
        ST_FINISH: state_q <= ST_IDLE;
        default:   state_q <= ST_IDLE;
      endcase
    end
  end

  assign fetch_req_o  = (state_q == ST_FETCH);
  assign fetch_addr_o = pc_q;
  assign exec_req_o   = (state_q == ST_ISSUE);
  assign exec_insn_o  = precise_q ? cur_insn_q : sel_insn;
  assign exec_addr_o  = precise_q ? pc_q : sel_addr;

  assign done_o      = (state_q == ST_FINISH);
  assign result_o    = done_o && ok_q;
  assign q_clear_o   = done_o && !precise_q;
  assign status_we_o = done_o && !precise_q;
  assign pc_we_o     = done_o && precise_q && ok_q;

  fpq_status_fix #(.XLEN(XLEN)) u_stat (
    .status_i (status_i),
    .all_ok_i (ok_q),
    .status_o (status_o)
  );

  fpq_pc_step #(.XLEN(XLEN), .STEP(PC_STEP)) u_pc (
    .npc_i (npc_q),
    .pc_o  (pc_o),
    .npc_o (npc_o)
  );

  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> !(done_o || fetch_req_o || exec_req_o || pc_we_o));
  p_one_port_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(fetch_req_o && exec_req_o));
  p_idx_bound_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exec_req_o && !precise_q) |-> (idx_q <= last_q));
  p_abort_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && exec_ack_i && !exec_ok_i) |=> (done_o && !result_o));
  p_status_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_we_o |-> (status_o[QSTAT_LO +: QSTAT_W] == '0 &&
                     status_o[XLEN-1:QSTAT_LO+QSTAT_W] == status_i[XLEN-1:QSTAT_LO+QSTAT_W]));
  p_clear_done_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    q_clear_o |-> done_o);
  p_done_pulse_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  p_pc_step_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_we_o |-> (result_o && npc_o == pc_o + XLEN'(PC_STEP)));
  p_precise_quiet_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !result_o) |-> !pc_we_o);
endmodule

// File: tb/sim_fpq_drain.sv
module sim_fpq_drain;
  localparam int QD = 8;
  localparam int XL = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic            start = 1'b0;
  logic [3:0]      q_depth = '0;
  logic [QD*XL-1:0] q_insn, q_addr;
  logic [XL-1:0]   pc = '0, npc = '0, status = '0;
  logic            fetch_req, fetch_ack = 1'b0, fetch_ok = 1'b0;
  logic [XL-1:0]   fetch_addr, fetch_data = '0;
  logic            exec_req, exec_ack = 1'b0, exec_ok = 1'b0;
  logic [XL-1:0]   exec_insn, exec_addr;
  logic            done, result, q_clear, status_we, pc_we;
  logic [XL-1:0]   status_out, pc_out, npc_out;

  fpq_drain #(.QDEPTH(QD), .XLEN(XL)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .q_depth_i(q_depth),
    .q_insn_i(q_insn), .q_addr_i(q_addr), .pc_i(pc), .npc_i(npc), .status_i(status),
    .fetch_req_o(fetch_req), .fetch_addr_o(fetch_addr), .fetch_ack_i(fetch_ack),
    .fetch_ok_i(fetch_ok), .fetch_data_i(fetch_data),
    .exec_req_o(exec_req), .exec_insn_o(exec_insn), .exec_addr_o(exec_addr),
    .exec_ack_i(exec_ack), .exec_ok_i(exec_ok),
    .done_o(done), .result_o(result), .q_clear_o(q_clear), .status_we_o(status_we),
    .status_o(status_out), .pc_we_o(pc_we), .pc_o(pc_out), .npc_o(npc_out)
  );

  int total = 0, bad = 0;
  int log_n = 0, fetch_n = 0, fail_at = -1, exec_lat = 1;
  logic fetch_pass = 1'b1;
  logic [XL-1:0] log_insn [16];
  logic [XL-1:0] log_addr [16];
  logic [XL-1:0] fetch_log_addr;
  logic c_res, c_clr, c_swe, c_pwe;
  logic [XL-1:0] c_stat, c_pc, c_npc;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  // execution unit model
  initial begin
    int cnt = 0;
    logic pend = 1'b0, okd = 1'b0;
    forever begin
      @(negedge clk);
      exec_ack = 1'b0;
      if (pend) begin
        if (cnt == 0) begin exec_ack = 1'b1; exec_ok = okd; pend = 1'b0; end
        else cnt--;
      end
      if (exec_req && !pend && !exec_ack) begin
        if (log_n < 16) begin log_insn[log_n] = exec_insn; log_addr[log_n] = exec_addr; end
        okd = (log_n != fail_at);
        log_n++;
        pend = 1'b1;
        cnt = exec_lat - 1;
      end
    end
  end

  // fetch port model
  initial begin
    logic pend = 1'b0;
    forever begin
      @(negedge clk);
      fetch_ack = 1'b0;
      if (pend) begin fetch_ack = 1'b1; fetch_ok = fetch_pass; pend = 1'b0; end
      else if (fetch_req) begin
        fetch_log_addr = fetch_addr;
        fetch_n++;
        pend = 1'b1;
      end
    end
  end

  task automatic fill_queue();
    for (int i = 0; i < QD; i++) begin
      q_insn[i*XL +: XL] = 32'h81A0_0000 + 32'(i * 37);
      q_addr[i*XL +: XL] = 32'h0001_0000 + 32'(i * 4);
    end
  endtask

  task automatic wait_done(input string req);
    int k = 0;
    while (!done && k < 400) begin @(negedge clk); k++; end
    check(req, {31'd0, done}, 32'd1);
    c_res = result; c_clr = q_clear; c_swe = status_we; c_pwe = pc_we;
    c_stat = status_out; c_pc = pc_out; c_npc = npc_out;
    @(negedge clk);
    check("R6 done pulse", {31'd0, done}, 32'd0);
  endtask

  task automatic run_op(input logic [3:0] depth, input string req);
    q_depth = depth;
    log_n = 0;
    fetch_n = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_done(req);
  endtask

  task automatic check_order(input int n);
    for (int i = 0; i < n; i++) begin
      check("R2 order insn", log_insn[i], q_insn[i*XL +: XL]);
      check("R2 order addr", log_addr[i], q_addr[i*XL +: XL]);
    end
  endtask

  task automatic t_reset();
    check("R1 done", {31'd0, done}, 32'd0);
    check("R1 reqs", {30'd0, fetch_req, exec_req}, 32'd0);
    check("R1 writes", {29'd0, q_clear, status_we, pc_we}, 32'd0);
  endtask

  task automatic t_queue_ok();
    status = 32'h1234_F7FF; fail_at = -1; exec_lat = 1;
    run_op(4'd3, "R2 done");
    check("R2 count", 32'(log_n), 32'd3);
    check_order(3);
    check("R6 result pass", {31'd0, c_res}, 32'd1);
    check("R4 status pass", c_stat, 32'h1234_F7FF & ~32'h0000_301F);
    check("R4 status we", {31'd0, c_swe}, 32'd1);
    check("R5 clear", {31'd0, c_clr}, 32'd1);
    check("R10 no pc on queue", {31'd0, c_pwe}, 32'd0);
    check("R7 no fetch on queue", 32'(fetch_n), 32'd0);
  endtask

  task automatic t_queue_full();
    status = 32'hFFFF_FFFF; fail_at = -1; exec_lat = 3;
    run_op(4'd8, "R2 full done");
    check("R2 full count", 32'(log_n), 32'd8);
    check_order(8);
    check("R6 full pass", {31'd0, c_res}, 32'd1);
    check("R4 full status", c_stat, 32'hFFFF_CFE0);
  endtask

  task automatic t_fail_mid();
    status = 32'h0000_3C15; fail_at = 2; exec_lat = 2;
    run_op(4'd5, "R3 done");
    check("R3 stop count", 32'(log_n), 32'd3);
    check_order(3);
    check("R6 result fail", {31'd0, c_res}, 32'd0);
    check("R4 status fail keeps cexc", c_stat, 32'h0000_0C15);
    check("R5 clear on fail", {31'd0, c_clr}, 32'd1);
    check("R4 we on fail", {31'd0, c_swe}, 32'd1);
  endtask

  task automatic t_fail_first();
    status = 32'h0000_101F; fail_at = 0; exec_lat = 1;
    run_op(4'd4, "R3 first done");
    check("R3 first count", 32'(log_n), 32'd1);
    check("R6 first fail", {31'd0, c_res}, 32'd0);
    check("R4 first status", c_stat, 32'h0000_001F);
  endtask

  task automatic t_precise_ok();
    pc = 32'h0000_4000; npc = 32'hFFFF_FFFC; fetch_data = 32'hC0DE_0029;
    fetch_pass = 1'b1; fail_at = -1; exec_lat = 2; status = 32'h0000_3000;
    run_op(4'd0, "R7 done");
    check("R7 fetch count", 32'(fetch_n), 32'd1);
    check("R7 fetch addr", fetch_log_addr, 32'h0000_4000);
    check("R7 exec count", 32'(log_n), 32'd1);
    check("R7 exec insn", log_insn[0], 32'hC0DE_0029);
    check("R7 exec addr", log_addr[0], 32'h0000_4000);
    check("R8 pc we", {31'd0, c_pwe}, 32'd1);
    check("R8 pc", c_pc, 32'hFFFF_FFFC);
    check("R8 npc wrap", c_npc, 32'h0000_0000);
    check("R8 pass", {31'd0, c_res}, 32'd1);
    check("R10 no status on precise", {30'd0, c_swe, c_clr}, 32'd0);
  endtask

  task automatic t_fetch_fail();
    pc = 32'h0000_8000; npc = 32'h0000_8004; fetch_pass = 1'b0;
    run_op(4'd0, "R9 done");
    check("R9 no exec", 32'(log_n), 32'd0);
    check("R9 result", {31'd0, c_res}, 32'd0);
    check("R9 pc we", {31'd0, c_pwe}, 32'd0);
    fetch_pass = 1'b1;
  endtask

  task automatic t_precise_fail();
    pc = 32'h0000_9000; npc = 32'h0000_9004; fail_at = 0; exec_lat = 1;
    run_op(4'd0, "R10 done");
    check("R10 exec count", 32'(log_n), 32'd1);
    check("R10 result", {31'd0, c_res}, 32'd0);
    check("R10 writes", {29'd0, c_pwe, c_swe, c_clr}, 32'd0);
  endtask

  task automatic t_start_busy();
    fail_at = -1; exec_lat = 2; status = 32'h0;
    q_depth = 4'd3; log_n = 0; fetch_n = 0;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    @(negedge clk); q_depth = 4'd0; start = 1'b1;
    @(negedge clk); start = 1'b0;
    wait_done("R11 done");
    repeat (12) @(negedge clk);
    check("R11 count", 32'(log_n), 32'd3);
    check("R11 no fetch", 32'(fetch_n), 32'd0);
    check("R11 result", {31'd0, c_res}, 32'd1);
    check("R11 idle after", {30'd0, fetch_req, exec_req}, 32'd0);
  endtask

  initial begin
    fill_queue();
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_queue_ok();
    t_queue_full();
    t_fail_mid();
    t_fail_first();
    t_precise_ok();
    t_fetch_fail();
    t_precise_fail();
    t_start_busy();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule